// File: doc/BRIEF.md
# AXI Command Range Decoder and Access Guard

This block sits on the read-address and write-address channels of one interconnect port. Every request address is compared with a small table of programmable mask/base ranges. The matching range gives the index of the target slave and the access rights of that window. Requests that pass are forwarded downstream, tagged with the slave index. A fixed-address burst is broken up into single-beat incrementing requests on the way.

A request is refused when it matches no enabled range, breaks the range's permission, uses a wrap length that is not supported, or uses the reserved burst code. A refused request never reaches a slave. The block answers it itself with a decode-error response: data beats on a dedicated error read channel, or a single write response after the write data has been swallowed. An illegal wrap size also sets a sticky fatal interrupt line, which software clears with a write-one-to-clear strobe.

Software loads the table one entry at a time through a plain write port. A surrounding response merge is expected to combine the error read and write channels with the slave responses.

Top module: `axi_range_guard`

## Requirements
- R1: A request matches table entry e when (addr & mask[e]) == base[e] and the entry is not disabled. When several entries match, the lowest-numbered one decides. The forwarded request carries that entry's slave index on m_arslv/m_awslv, together with the original address, ID and size. Several entries may name the same slave.
- R2: On reset all entries are disabled and the fatal interrupt is clear. Every request is then refused until software writes entries through cfg_we/cfg_idx.
- R3: The 2-bit permission field works as follows: bit 0 allows reads and bit 1 allows writes. So 00 is disabled, 01 is read-only, 10 is write-only and 11 is read-write. A read to a range without bit 0, or a write to a range without bit 1, is refused.
- R4: An entry whose privileged flag is set accepts only requests with prot[0]=1. Any other request to it is refused.
- R5: A refused read produces len+1 beats on the e_r channel. Each beat has e_rresp=2'b11 and the request's ID, and e_rlast is set on the last beat only. Nothing is sent on m_ar.
- R6: For a refused write, the write data beats are accepted and not passed to m_w, up to and including the beat with s_wlast. After that, exactly one e_b response is sent with e_bresp=2'b11 and the request's ID.
- R7: While a channel is forwarding a request or answering a refused one, its s_arready/s_awready is low.
- R8: A FIXED burst (burst code 2'b00) of len+1 beats is sent as len+1 separate requests. Each has burst code INCR (2'b01), length 0 and the unchanged address.
- R9: INCR (2'b01) and legal WRAP (2'b10) requests are forwarded once with unchanged length and burst code. A WRAP is legal when (len+1)·2^size equals 16, 32 or 64 bytes.
- R10: A WRAP request of any other total size is refused and sets irq_fatal. A request with burst code 2'b11 is refused.
- R11: irq_fatal stays high until a cycle with irq_clr high and no new illegal wrap; a new illegal wrap takes priority over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Table entry write strobe |
| cfg_idx | input | EIW | Entry number to write |
| cfg_mask | input | AW | Address mask of the entry |
| cfg_base | input | AW | Base address of the entry |
| cfg_perm | input | 2 | Permission code (bit0 read, bit1 write) |
| cfg_priv | input | 1 | Entry requires privileged access |
| cfg_slv | input | SW | Slave index of the entry |
| irq_clr | input | 1 | Clears the fatal interrupt |
| irq_fatal | output | 1 | Sticky fatal interrupt for illegal wraps |
| s_arvalid | input | 1 | Upstream read request valid |
| s_arready | output | 1 | Upstream read request ready |
| s_araddr | input | AW | Read address |
| s_arid | input | IW | Read ID |
| s_arlen | input | 8 | Read burst length minus one |
| s_arsize | input | 3 | Read beat size code |
| s_arburst | input | 2 | Read burst type |
| s_arprot | input | 3 | Read protection attribute |
| m_arvalid | output | 1 | Downstream read request valid |
| m_arready | input | 1 | Downstream read request ready |
| m_araddr | output | AW | Forwarded read address |
| m_arid | output | IW | Forwarded read ID |
| m_arlen | output | 8 | Forwarded read length |
| m_arsize | output | 3 | Forwarded read size |
| m_arburst | output | 2 | Forwarded read burst type |
| m_arslv | output | SW | Target slave of the read |
| s_awvalid | input | 1 | Upstream write request valid |
| s_awready | output | 1 | Upstream write request ready |
| s_awaddr | input | AW | Write address |
| s_awid | input | IW | Write ID |
| s_awlen | input | 8 | Write burst length minus one |
| s_awsize | input | 3 | Write beat size code |
| s_awburst | input | 2 | Write burst type |
| s_awprot | input | 3 | Write protection attribute |
| m_awvalid | output | 1 | Downstream write request valid |
| m_awready | input | 1 | Downstream write request ready |
| m_awaddr | output | AW | Forwarded write address |
| m_awid | output | IW | Forwarded write ID |
| m_awlen | output | 8 | Forwarded write length |
| m_awsize | output | 3 | Forwarded write size |
| m_awburst | output | 2 | Forwarded write burst type |
| m_awslv | output | SW | Target slave of the write |
| s_wvalid | input | 1 | Upstream write data valid |
| s_wready | output | 1 | Upstream write data ready |
| s_wdata | input | DW | Write data |
| s_wlast | input | 1 | Last write data beat |
| m_wvalid | output | 1 | Downstream write data valid |
| m_wready | input | 1 | Downstream write data ready |
| m_wdata | output | DW | Forwarded write data |
| m_wlast | output | 1 | Forwarded last beat |
| e_rvalid | output | 1 | Error read beat valid |
| e_rready | input | 1 | Error read beat ready |
| e_rid | output | IW | Error read ID |
| e_rresp | output | 2 | Error read response code |
| e_rlast | output | 1 | Last error read beat |
| e_bvalid | output | 1 | Error write response valid |
| e_bready | input | 1 | Error write response ready |
| e_bid | output | IW | Error write response ID |
| e_bresp | output | 2 | Error write response code |

## Verification
The assertions rely on three properties of the inputs. Downstream readies and error readies may stall at any time. Write data of a burst arrives only after its write request has been accepted, and its s_wlast falls on the last beat. The irq_clr strobe is a plain level. The stimulus issues one request at a time per channel and drives write beats only after the request handshake, counting them so that s_wlast always matches the request length. Wrap lengths, burst codes, protection bits and addresses are drawn at random over both legal and illegal values. The ready lines are toggled at random on every cycle.

// File: rtl/axi_range_guard.sv
module axi_range_guard #(
  parameter int AW = 32,
  parameter int IW = 4,
  parameter int DW = 32,
  parameter int NE = 8,
  parameter int SW = 2,
  localparam int EIW = (NE > 1) ? $clog2(NE) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cfg_we,
  input  logic [EIW-1:0] cfg_idx,
  input  logic [AW-1:0]  cfg_mask,
  input  logic [AW-1:0]  cfg_base,
  input  logic [1:0]     cfg_perm,
  input  logic           cfg_priv,
  input  logic [SW-1:0]  cfg_slv,
  input  logic           irq_clr,
  output logic           irq_fatal,
  input  logic           s_arvalid,
  output logic           s_arready,
  input  logic [AW-1:0]  s_araddr,
  input  logic [IW-1:0]  s_arid,
  input  logic [7:0]     s_arlen,
  input  logic [2:0]     s_arsize,
  input  logic [1:0]     s_arburst,
  input  logic [2:0]     s_arprot,
  output logic           m_arvalid,
  input  logic           m_arready,
  output logic [AW-1:0]  m_araddr,
  output logic [IW-1:0]  m_arid,
  output logic [7:0]     m_arlen,
  output logic [2:0]     m_arsize,
  output logic [1:0]     m_arburst,
  output logic [SW-1:0]  m_arslv,
  input  logic           s_awvalid,
  output logic           s_awready,
  input  logic [AW-1:0]  s_awaddr,
  input  logic [IW-1:0]  s_awid,
  input  logic [7:0]     s_awlen,
  input  logic [2:0]     s_awsize,
  input  logic [1:0]     s_awburst,
  input  logic [2:0]     s_awprot,
  output logic           m_awvalid,
  input  logic           m_awready,
  output logic [AW-1:0]  m_awaddr,
  output logic [IW-1:0]  m_awid,
  output logic [7:0]     m_awlen,
  output logic [2:0]     m_awsize,
  output logic [1:0]     m_awburst,
  output logic [SW-1:0]  m_awslv,
  input  logic           s_wvalid,
  output logic           s_wready,
  input  logic [DW-1:0]  s_wdata,
  input  logic           s_wlast,
  output logic           m_wvalid,
  input  logic           m_wready,
  output logic [DW-1:0]  m_wdata,
  output logic           m_wlast,
  output logic           e_rvalid,
  input  logic           e_rready,
  output logic [IW-1:0]  e_rid,
  output logic [1:0]     e_rresp,
  output logic           e_rlast,
  output logic           e_bvalid,
  input  logic           e_bready,
  output logic [IW-1:0]  e_bid,
  output logic [1:0]     e_bresp
);

  logic [AW-1:0] mask_q [NE];
  logic [AW-1:0] base_q [NE];
  logic [1:0]    perm_q [NE];
  logic          priv_q [NE];
  logic [SW-1:0] slv_q  [NE];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      for (int e = 0; e < NE; e++) begin
        mask_q[e] <= '0; base_q[e] <= '0; perm_q[e] <= 2'b00;
        priv_q[e] <= 1'b0; slv_q[e] <= '0;
      end
    end else if (cfg_we) begin
      mask_q[cfg_idx] <= cfg_mask;
      base_q[cfg_idx] <= cfg_base;
      perm_q[cfg_idx] <= cfg_perm;
      priv_q[cfg_idx] <= cfg_priv;
      slv_q[cfg_idx]  <= cfg_slv;
    end

  logic [1:0]          iv, ipv, ir, badw;
  logic [1:0][AW-1:0]  ia;
  logic [1:0][IW-1:0]  iid;
  logic [1:0][7:0]     ilen;
  logic [1:0][2:0]     isz;
  logic [1:0][1:0]     ib;
  logic                wdrain;
  logic                unused_prot;

  assign iv   = {s_awvalid, s_arvalid};
  assign ipv  = {s_awprot[0], s_arprot[0]};
  assign ia   = {s_awaddr, s_araddr};
  assign iid  = {s_awid, s_arid};
  assign ilen = {s_awlen, s_arlen};
  assign isz  = {s_awsize, s_arsize};
  assign ib   = {s_awburst, s_arburst};
  assign unused_prot = ^{s_arprot[2:1], s_awprot[2:1]};

  for (genvar c = 0; c < 2; c++) begin : g_ch
    typedef enum logic [1:0] {IDLE, FWD, ERR, RESP} st_t;
    st_t           st;
    logic [AW-1:0] qa;
    logic [IW-1:0] qid;
    logic [7:0]    qlen, cnt;
    logic [2:0]    qsz;
    logic [1:0]    qb;
    logic [SW-1:0] qslv;
    logic          hit, wlegal, ok, acc;
    logic [EIW-1:0] hix;
    logic [15:0]   wbytes;

    always_comb begin
      hit = 1'b0;
      hix = '0;
      for (int e = NE - 1; e >= 0; e--)
        if (perm_q[e] != 2'b00 && (ia[c] & mask_q[e]) == base_q[e]) begin
          hit = 1'b1;
          hix = EIW'(e);
        end
    end

    assign wbytes = (16'(ilen[c]) + 16'd1) << isz[c];
    assign wlegal = wbytes == 16'd16 || wbytes == 16'd32 || wbytes == 16'd64;
    assign ok = hit && perm_q[hix][c] && (!priv_q[hix] || ipv[c]) &&
                ib[c] != 2'b11 && (ib[c] != 2'b10 || wlegal);
    assign ir[c]   = st == IDLE;
    assign acc     = iv[c] && ir[c];
    assign badw[c] = acc && ib[c] == 2'b10 && !wlegal;

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
        st <= IDLE; qa <= '0; qid <= '0; qlen <= '0; cnt <= '0;
        qsz <= '0; qb <= '0; qslv <= '0;
      end else begin
        case (st)
          IDLE: if (acc) begin
            qa <= ia[c]; qid <= iid[c]; qlen <= ilen[c]; qsz <= isz[c];
            qb <= ib[c]; qslv <= slv_q[hix];
            cnt <= (!ok || ib[c] == 2'b00) ? ilen[c] : 8'd0;
            st <= ok ? FWD : ERR;
          end
          FWD: if (c == 0 ? m_arready : m_awready) begin
            if (cnt == 8'd0) st <= IDLE;
            else cnt <= cnt - 8'd1;
          end
          ERR:
            if (c == 0) begin
              if (e_rready) begin
                if (cnt == 8'd0) st <= IDLE;
                else cnt <= cnt - 8'd1;
              end
            end else if (s_wvalid && s_wlast) st <= RESP;
          RESP: if (e_bready) st <= IDLE;
          default: st <= IDLE;
        endcase
      end

    if (c == 0) begin : g_rd
      assign m_arvalid = st == FWD;
      assign m_araddr  = qa;
      assign m_arid    = qid;
      assign m_arlen   = qb == 2'b00 ? 8'd0 : qlen;
      assign m_arsize  = qsz;
      assign m_arburst = qb == 2'b00 ? 2'b01 : qb;
      assign m_arslv   = qslv;
      assign e_rvalid  = st == ERR;
      assign e_rid     = qid;
      assign e_rlast   = cnt == 8'd0;
    end else begin : g_wr
      assign m_awvalid = st == FWD;
      assign m_awaddr  = qa;
      assign m_awid    = qid;
      assign m_awlen   = qb == 2'b00 ? 8'd0 : qlen;
      assign m_awsize  = qsz;
      assign m_awburst = qb == 2'b00 ? 2'b01 : qb;
      assign m_awslv   = qslv;
      assign wdrain    = st == ERR;
      assign e_bvalid  = st == RESP;
      assign e_bid     = qid;
    end
  end

  assign s_arready = ir[0];
  assign s_awready = ir[1];
  assign e_rresp   = 2'b11;
  assign e_bresp   = 2'b11;
  assign s_wready  = wdrain | m_wready;
  assign m_wvalid  = s_wvalid & ~wdrain;
  assign m_wdata   = s_wdata;
  assign m_wlast   = s_wlast;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) irq_fatal <= 1'b0;
    else if (|badw) irq_fatal <= 1'b1;
    else if (irq_clr) irq_fatal <= 1'b0;

endmodule

// File: rtl/axi_range_guard_chk.sv
module axi_range_guard_chk #(
  parameter int AW = 32,
  parameter int IW = 4,
  parameter int SW = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic          irq_clr,
  input logic          irq_fatal,
  input logic          s_arvalid,
  input logic          s_arready,
  input logic [7:0]    s_arlen,
  input logic [2:0]    s_arsize,
  input logic [1:0]    s_arburst,
  input logic          m_arvalid,
  input logic          m_arready,
  input logic [AW-1:0] m_araddr,
  input logic [1:0]    m_arburst,
  input logic [SW-1:0] m_arslv,
  input logic          s_awvalid,
  input logic          s_awready,
  input logic [7:0]    s_awlen,
  input logic [2:0]    s_awsize,
  input logic [1:0]    s_awburst,
  input logic          m_awvalid,
  input logic [7:0]    m_awlen,
  input logic [2:0]    m_awsize,
  input logic [1:0]    m_awburst,
  input logic          e_rvalid,
  input logic          e_rready,
  input logic [IW-1:0] e_rid,
  input logic          e_bvalid
);
  logic [15:0] ar_bytes, aw_bytes, maw_bytes;
  logic        bad_ar, bad_aw;
  assign ar_bytes  = (16'(s_arlen) + 16'd1) << s_arsize;
  assign aw_bytes  = (16'(s_awlen) + 16'd1) << s_awsize;
  assign maw_bytes = (16'(m_awlen) + 16'd1) << m_awsize;
  assign bad_ar = s_arvalid && s_arready && s_arburst == 2'b10 &&
                  !(ar_bytes == 16'd16 || ar_bytes == 16'd32 || ar_bytes == 16'd64);
  assign bad_aw = s_awvalid && s_awready && s_awburst == 2'b10 &&
                  !(aw_bytes == 16'd16 || aw_bytes == 16'd32 || aw_bytes == 16'd64);

  // R1
  ar_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    m_arvalid && !m_arready |=> m_arvalid && $stable(m_araddr) && $stable(m_arslv));
  // R5
  rerr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    e_rvalid && !e_rready |=> e_rvalid && $stable(e_rid));
  // R6
  bresp_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    m_awvalid |-> !e_bvalid);
  // R7
  rd_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (e_rvalid || m_arvalid) |-> !s_arready);
  // R7
  wr_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (e_bvalid || m_awvalid) |-> !s_awready);
  // R8
  no_fixed_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (m_arvalid || m_awvalid) |-> (m_arburst != 2'b00 && m_awburst != 2'b00));
  // R9
  wrap_out_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    m_awvalid && m_awburst == 2'b10 |->
      (maw_bytes == 16'd16 || maw_bytes == 16'd32 || maw_bytes == 16'd64));
  // R10
  irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_fatal) |-> $past(bad_ar || bad_aw));
  // R11
  irq_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_fatal && !irq_clr |=> irq_fatal);
endmodule

bind axi_range_guard axi_range_guard_chk #(.AW(AW), .IW(IW), .SW(SW)) u_chk (.*);

// File: tb/axi_range_guard_test.sv
module axi_range_guard_test;
  localparam int AW = 32, IW = 4, DW = 32, NE = 8, SW = 2, EIW = 3;

  logic clk = 0, rst_n = 0;
  logic cfg_we = 0, cfg_priv = 0, irq_clr = 0, irq_fatal;
  logic [EIW-1:0] cfg_idx = 0;
  logic [AW-1:0] cfg_mask = 0, cfg_base = 0;
  logic [1:0] cfg_perm = 0;
  logic [SW-1:0] cfg_slv = 0;
  logic s_arvalid = 0, s_arready, m_arvalid, m_arready = 0;
  logic [AW-1:0] s_araddr = 0, m_araddr;
  logic [IW-1:0] s_arid = 0, m_arid;
  logic [7:0] s_arlen = 0, m_arlen;
  logic [2:0] s_arsize = 0, s_arprot = 0, m_arsize;
  logic [1:0] s_arburst = 0, m_arburst;
  logic [SW-1:0] m_arslv;
  logic s_awvalid = 0, s_awready, m_awvalid, m_awready = 0;
  logic [AW-1:0] s_awaddr = 0, m_awaddr;
  logic [IW-1:0] s_awid = 0, m_awid;
  logic [7:0] s_awlen = 0, m_awlen;
  logic [2:0] s_awsize = 0, s_awprot = 0, m_awsize;
  logic [1:0] s_awburst = 0, m_awburst;
  logic [SW-1:0] m_awslv;
  logic s_wvalid = 0, s_wready, s_wlast = 0, m_wvalid, m_wready = 0, m_wlast;
  logic [DW-1:0] s_wdata = 0, m_wdata;
  logic e_rvalid, e_rready = 0, e_rlast, e_bvalid, e_bready = 0;
  logic [IW-1:0] e_rid, e_bid;
  logic [1:0] e_rresp, e_bresp;

  axi_range_guard #(.AW(AW), .IW(IW), .DW(DW), .NE(NE), .SW(SW)) uut (.*);

  always #5 clk = ~clk;

  logic [AW-1:0] t_mask [NE];
  logic [AW-1:0] t_base [NE];
  logic [1:0]    t_perm [NE];
  logic          t_priv [NE];
  logic [SW-1:0] t_slv  [NE];
  int total = 0, bad = 0;
  int last_fw, last_err;
  bit done = 0;

  task automatic chk(string tag, longint act, longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic cfg(int idx, logic [AW-1:0] m, logic [AW-1:0] b, logic [1:0] p, logic pv, logic [SW-1:0] sl);
    @(negedge clk);
    cfg_we = 1; cfg_idx = EIW'(idx); cfg_mask = m; cfg_base = b; cfg_perm = p; cfg_priv = pv; cfg_slv = sl;
    @(negedge clk);
    cfg_we = 0;
    t_mask[idx] = m; t_base[idx] = b; t_perm[idx] = p; t_priv[idx] = pv; t_slv[idx] = sl;
  endtask

  function automatic void model(input logic [AW-1:0] a, input bit w, input logic [2:0] prot,
      input logic [7:0] len, input logic [2:0] sz, input logic [1:0] b,
      output bit ok, output logic [SW-1:0] slv, output bit badwrap);
    bit hit = 0;
    int e_sel = 0;
    int bytes = (int'(len) + 1) << sz;
    bit legal = bytes == 16 || bytes == 32 || bytes == 64;
    for (int e = NE - 1; e >= 0; e--)
      if (t_perm[e] != 0 && (a & t_mask[e]) == t_base[e]) begin hit = 1; e_sel = e; end
    slv = t_slv[e_sel];
    ok = hit && (w ? t_perm[e_sel][1] : t_perm[e_sel][0]) && (!t_priv[e_sel] || prot[0]) &&
         b != 2'b11 && (b != 2'b10 || legal);
    badwrap = b == 2'b10 && !legal;
  endfunction

  task automatic rd(logic [AW-1:0] a, logic [IW-1:0] id, logic [7:0] len, logic [2:0] sz,
                    logic [1:0] b, logic [2:0] prot);
    bit ok, bw;
    logic [SW-1:0] slv;
    int fbad = 0, ebad = 0, sbad = 0, guard = 0;
    model(a, 0, prot, len, sz, b, ok, slv, bw);
    @(negedge clk);
    chk("R7 idle ready", s_arready, 1);
    s_arvalid = 1; s_araddr = a; s_arid = id; s_arlen = len; s_arsize = sz; s_arburst = b; s_arprot = prot;
    @(negedge clk);
    s_arvalid = 0;
    last_fw = 0; last_err = 0;
    while (!(s_arready && !m_arvalid && !e_rvalid) && guard < 2000) begin
      m_arready = ($urandom % 4) != 0;
      e_rready  = ($urandom % 4) != 0;
      #1;
      if (m_arvalid) begin
        if (m_araddr != a || m_arid != id || m_arslv != slv || m_arsize != sz ||
            m_arlen != (b == 2'b00 ? 8'd0 : len) || m_arburst != (b == 2'b00 ? 2'b01 : b)) fbad++;
        if (m_arready) last_fw++;
      end
      if (e_rvalid) begin
        if (e_rid != id || e_rresp != 2'b11 || e_rlast != (last_err == int'(len))) ebad++;
        if (e_rready) last_err++;
      end
      if ((m_arvalid || e_rvalid) && s_arready) sbad++;
      @(negedge clk);
      guard++;
    end
    m_arready = 0; e_rready = 0;
    chk("R7 read stall", sbad, 0);
    if (ok) begin
      chk("R1 read fields", fbad, 0);
      chk(b == 2'b00 ? "R8 fixed read split count" : "R9 read forward count",
          last_fw, b == 2'b00 ? int'(len) + 1 : 1);
      chk("R5 no error beats on pass", last_err, 0);
    end else begin
      chk("R5 error beats", last_err, int'(len) + 1);
      chk("R5 error beat fields", ebad, 0);
      chk("R5 nothing forwarded", last_fw, 0);
    end
    if (bw) chk("R10 irq on bad wrap", irq_fatal, 1);
  endtask

  task automatic wr(logic [AW-1:0] a, logic [IW-1:0] id, logic [7:0] len, logic [2:0] sz,
                    logic [1:0] b, logic [2:0] prot);
    bit ok, bw;
    logic [SW-1:0] slv;
    int fbad = 0, bbad = 0, sbad = 0, guard = 0, wleft = int'(len) + 1, wfw = 0, leak = 0;
    model(a, 1, prot, len, sz, b, ok, slv, bw);
    @(negedge clk);
    chk("R7 idle ready", s_awready, 1);
    s_awvalid = 1; s_awaddr = a; s_awid = id; s_awlen = len; s_awsize = sz; s_awburst = b; s_awprot = prot;
    @(negedge clk);
    s_awvalid = 0;
    last_fw = 0; last_err = 0;
    while (!(s_awready && !m_awvalid && !e_bvalid && wleft == 0) && guard < 2000) begin
      m_awready = ($urandom % 4) != 0;
      e_bready  = ($urandom % 4) != 0;
      m_wready  = ($urandom % 4) != 0;
      s_wvalid  = wleft > 0 && ($urandom % 3) != 0;
      s_wlast   = wleft == 1;
      s_wdata   = $urandom;
      #1;
      if (m_awvalid) begin
        if (m_awaddr != a || m_awid != id || m_awslv != slv || m_awsize != sz ||
            m_awlen != (b == 2'b00 ? 8'd0 : len) || m_awburst != (b == 2'b00 ? 2'b01 : b)) fbad++;
        if (m_awready) last_fw++;
      end
      if (m_wvalid) begin
        if (ok && m_wready) wfw++;
        if (!ok) leak++;
      end
      if (e_bvalid) begin
        if (e_bid != id || e_bresp != 2'b11 || wleft != 0) bbad++;
        if (e_bready) last_err++;
      end
      if ((m_awvalid || e_bvalid) && s_awready) sbad++;
      if (s_wvalid && s_wready) wleft--;
      @(negedge clk);
      guard++;
    end
    s_wvalid = 0; s_wlast = 0; m_awready = 0; e_bready = 0; m_wready = 0;
    chk("R7 write stall", sbad, 0);
    if (ok) begin
      chk("R1 write fields", fbad, 0);
      chk(b == 2'b00 ? "R8 fixed write split count" : "R9 write forward count",
          last_fw, b == 2'b00 ? int'(len) + 1 : 1);
      chk("R9 write data forwarded", wfw, int'(len) + 1);
      chk("R6 no B on pass", last_err, 0);
    end else begin
      chk("R6 single B", last_err, 1);
      chk("R6 B fields after drain", bbad, 0);
      chk("R6 data not leaked", leak, 0);
      chk("R6 nothing forwarded", last_fw, 0);
    end
    if (bw) chk("R10 irq on bad wrap", irq_fatal, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL R7 watchdog act=hung exp=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    for (int e = 0; e < NE; e++) begin
      t_mask[e] = 0; t_base[e] = 0; t_perm[e] = 0; t_priv[e] = 0; t_slv[e] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R2 reset irq", irq_fatal, 0);
    chk("R2 reset ar ready", s_arready, 1);
    chk("R2 reset aw ready", s_awready, 1);
    chk("R2 reset no fwd", m_arvalid | m_awvalid, 0);
    chk("R2 reset no err", e_rvalid | e_bvalid, 0);
    rd(32'h1000_0040, 4'h3, 8'd2, 3'd2, 2'b01, 3'b001);
    chk("R2 empty table refuses read", last_err, 3);
    wr(32'h1000_0040, 4'h4, 8'd1, 3'd2, 2'b01, 3'b001);
    chk("R2 empty table refuses write", last_err, 1);

    cfg(0, 32'hFFFF_0000, 32'h1000_0000, 2'b11, 0, 2'd1);
    cfg(1, 32'hFFFF_F000, 32'h1000_0000, 2'b01, 0, 2'd2);
    cfg(2, 32'hFFFF_0000, 32'h2000_0000, 2'b01, 0, 2'd3);
    cfg(3, 32'hFFFF_0000, 32'h3000_0000, 2'b10, 0, 2'd3);
    cfg(4, 32'hFFFF_0000, 32'h4000_0000, 2'b11, 1, 2'd0);
    cfg(5, 32'hFFFF_0000, 32'h5000_0000, 2'b00, 0, 2'd1);

    rd(32'h1000_0100, 4'h1, 8'd3, 3'd2, 2'b01, 3'b000);
    chk("R1 lowest entry wins", last_fw, 1);
    rd(32'h3000_0010, 4'h2, 8'd1, 3'd2, 2'b01, 3'b000);
    chk("R3 read to write-only refused", last_err, 2);
    wr(32'h3000_0010, 4'h5, 8'd1, 3'd2, 2'b01, 3'b000);
    chk("R3 write to write-only passes", last_fw, 1);
    wr(32'h2000_0000, 4'h6, 8'd2, 3'd2, 2'b01, 3'b000);
    chk("R3 write to read-only refused", last_err, 1);
    rd(32'h2000_0000, 4'h7, 8'd0, 3'd2, 2'b01, 3'b000);
    chk("R3 read to read-only passes", last_fw, 1);
    rd(32'h5000_0000, 4'h8, 8'd0, 3'd2, 2'b01, 3'b001);
    chk("R3 disabled entry refused", last_err, 1);
    rd(32'h4000_0000, 4'h9, 8'd1, 3'd2, 2'b01, 3'b000);
    chk("R4 unprivileged refused", last_err, 2);
    rd(32'h4000_0000, 4'h9, 8'd1, 3'd2, 2'b01, 3'b001);
    chk("R4 privileged passes", last_fw, 1);
    rd(32'h1000_0200, 4'hA, 8'd3, 3'd2, 2'b00, 3'b000);
    chk("R8 fixed read four pieces", last_fw, 4);
    wr(32'h1000_0200, 4'hB, 8'd2, 3'd2, 2'b00, 3'b000);
    chk("R8 fixed write three pieces", last_fw, 3);
    rd(32'h1000_0300, 4'hC, 8'd3, 3'd2, 2'b10, 3'b000);
    chk("R9 wrap 16B passes", last_fw, 1);
    wr(32'h1000_0300, 4'hD, 8'd7, 3'd3, 2'b10, 3'b000);
    chk("R9 wrap 64B passes", last_fw, 1);
    chk("R10 legal wraps leave irq clear", irq_fatal, 0);
    rd(32'h1000_0300, 4'hE, 8'd1, 3'd2, 2'b10, 3'b000);
    chk("R10 wrap 8B refused", last_err, 2);
    repeat (3) @(negedge clk);
    chk("R11 irq sticky", irq_fatal, 1);
    irq_clr = 1;
    @(negedge clk);
    irq_clr = 0;
    chk("R11 irq cleared", irq_fatal, 0);
    rd(32'h1000_0300, 4'hF, 8'd0, 3'd2, 2'b11, 3'b000);
    chk("R10 reserved burst refused", last_err, 1);
    chk("R10 reserved burst no irq", irq_fatal, 0);
    rd(32'h9000_0000, 4'h1, 8'd7, 3'd2, 2'b01, 3'b000);
    chk("R5 unmapped eight beats", last_err, 8);

    for (int e = 0; e < NE; e++) begin
      logic [AW-1:0] m;
      case ($urandom % 3)
        0: m = 32'hFFFF_0000;
        1: m = 32'hFFFF_F000;
        default: m = 32'hFF00_0000;
      endcase
      cfg(e, m, $urandom & m, 2'($urandom), 1'($urandom), 2'($urandom));
    end
    for (int n = 0; n < 300; n++) begin
      logic [AW-1:0] a;
      logic [7:0] len;
      logic [1:0] b;
      int e = $urandom % NE;
      a = ($urandom % 4 == 0) ? $urandom : (t_base[e] | ($urandom & ~t_mask[e]));
      b = 2'($urandom);
      len = (b == 2'b10) ? 8'((1 << ($urandom % 5)) - 1) : 8'($urandom % 8);
      if (n % 2 == 0) rd(a, 4'($urandom), len, 3'($urandom % 4), b, 3'($urandom));
      else wr(a, 4'($urandom), len, 3'($urandom % 4), b, 3'($urandom));
      if (irq_fatal) begin
        @(negedge clk); irq_clr = 1;
        @(negedge clk); irq_clr = 0;
        chk("R11 irq clear in random run", irq_fatal, 0);
      end
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule